// File: doc/BRIEF.md
# Codec Response Ring Dispatcher

This block empties a circular ring of codec responses. A producer fills ring slots through a write port and then advertises a new write pointer. The dispatcher walks the ring from its own read position up to that pointer, one entry per clock. Each entry pairs a 32-bit response word with a 32-bit extended word. The extended word names the codec that sent the entry and says whether the entry is an unsolicited event.

For every supported codec the block keeps a count of commands that still await a reply. A command-issue strobe raises that count. A solicited reply lowers it and becomes the codec's stored last response. A reply that arrives while the count is zero is reported as spurious. Unsolicited events go out on an event port that a downstream FIFO accepts, and the walk pauses while that FIFO reports full. An entry that names a codec address outside the supported range raises a sticky fatal flag.

Top module: `response_ring_dispatcher`

## Requirements
- R1: After reset every codec_done bit is 1, spur_flag, fatal_flag and evt_push are 0, and rd_last reads 0 for every codec.
- R2: When the low 8 bits of prod_wp differ from the last accepted value, the block consumes entries one per cycle until its read position equals that value. Before each read it advances the read position, so the first entry read after reset is index 1 and entry 0 is skipped.
- R3: The read position wraps modulo 256, so after index 255 the next entry read is index 0.
- R4: A ring write stores ring_wr_resp as the response word and ring_wr_ext as the extended word. Extended-word bits [3:0] give the codec address and bit 4 set marks an unsolicited event.
- R5: A solicited entry for a codec whose pending count is nonzero stores its response word as that codec's last response and lowers the count by one. codec_done[i] is 1 exactly when codec i has no pending commands.
- R6: A solicited entry for a codec with a zero pending count pulses spur_flag for one cycle and leaves every stored response and count unchanged.
- R7: An entry whose codec address is NUM_CODECS (default 4) or higher sets fatal_flag, which stays set until reset. The entry is consumed and nothing else changes.
- R8: An unsolicited entry for a valid codec is shown on evt_resp/evt_ext with evt_push high for one cycle, in ring order, and leaves counts and stored responses untouched.
- R9: While evt_full is 1, an unsolicited entry is not pushed and the read position holds, so later entries wait behind it.
- R10: A prod_wp value of 0xFFFF is ignored, and no entry is consumed because of it.
- R11: A cmd_issue strobe raises the pending count of codec cmd_codec by one, and a strobe for an address of NUM_CODECS or higher has no effect. A strobe and a solicited reply for the same codec in the same cycle leave its count unchanged.
- R12: rd_last shows, combinationally, the last stored response of the codec selected by rd_codec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_wr_en | input | 1 | Ring slot write strobe |
| ring_wr_idx | input | 8 | Ring slot written |
| ring_wr_resp | input | 32 | Response word to store |
| ring_wr_ext | input | 32 | Extended word to store |
| prod_wp | input | 16 | Producer write pointer (0xFFFF means powered down) |
| cmd_issue | input | 1 | A command was sent to codec cmd_codec |
| cmd_codec | input | 4 | Codec address of the issued command |
| evt_full | input | 1 | Event FIFO cannot accept an entry |
| evt_push | output | 1 | Event entry offered this cycle |
| evt_resp | output | 32 | Response word of the event |
| evt_ext | output | 32 | Extended word of the event |
| rd_codec | input | 4 | Codec whose last response is read |
| rd_last | output | 32 | Last response of codec rd_codec |
| codec_done | output | 4 | Per-codec: no command pending |
| spur_flag | output | 1 | One-cycle pulse for a reply that nothing awaited |
| fatal_flag | output | 1 | Sticky: an entry named an unsupported codec |

## Verification
The assertions check on every cycle that the read position steps by exactly one while work is available and the FIFO is not full, and that it holds during an event stall. They also check that a powered-down pointer never changes the target, that fatal_flag never clears, that no push happens into a full FIFO, and that a count is never lowered from zero. Only the bench scenarios can show that the right entries reach the right codec. These cover skipping entry 0 after reset, wrap-around to index 0, spurious classification, event ordering, and the cancelling of a command strobe against a reply in the same cycle.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int UNSOL_BIT  = 4;
    localparam int WP_W       = 16;
    localparam logic [WP_W-1:0] WP_DEAD = 16'hFFFF;

    typedef enum logic [2:0] {
        K_IDLE,
        K_FATAL,
        K_EVENT,
        K_REPLY,
        K_SPUR
    } entry_kind_e;
endpackage

// File: rtl/rrd_ring_ram.sv
module rrd_ring_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/rrd_codec_bank.sv
module rrd_codec_bank
    import rrd_pkg::*;
#(
    parameter int NUM_CODECS = 4,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_en,
    input  logic [ADDR_W-1:0]     inc_addr,
    input  logic                  dec_en,
    input  logic [ADDR_W-1:0]     dec_addr,
    input  logic [WORD_W-1:0]     dec_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    output logic [NUM_CODECS-1:0] zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_CODECS-1:0][CNT_W-1:0]  cnt;
        logic [NUM_CODECS-1:0][WORD_W-1:0] last;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NUM_CODECS; i++) begin
            logic dec_i;
            logic inc_i;
            dec_i = dec_en && (dec_addr == ADDR_W'(i));
            inc_i = inc_en && (inc_addr == ADDR_W'(i)) &&
                    ((b_q.cnt[i] != CNT_MAX) || dec_i);
            if (dec_i) b_d.last[i] = dec_data;
            if (inc_i && !dec_i)      b_d.cnt[i] = b_q.cnt[i] + 1'b1;
            else if (dec_i && !inc_i) b_d.cnt[i] = b_q.cnt[i] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CODECS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = b_q.last[i];
        end
    end

    for (genvar g = 0; g < NUM_CODECS; g++) begin : g_codec
        assign zero[g] = (b_q.cnt[g] == '0);

        // R5
        dec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && dec_addr == ADDR_W'(g)) |-> (b_q.cnt[g] != '0));
    end
endmodule

// File: rtl/response_ring_dispatcher.sv
module response_ring_dispatcher
    import rrd_pkg::*;
#(
    parameter int RING_DEPTH = 256,
    parameter int NUM_CODECS = 4,
    parameter int CNT_W      = 8,
    localparam int PTR_W     = $clog2(RING_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ring_wr_en,
    input  logic [PTR_W-1:0]      ring_wr_idx,
    input  logic [WORD_W-1:0]     ring_wr_resp,
    input  logic [WORD_W-1:0]     ring_wr_ext,
    input  logic [WP_W-1:0]       prod_wp,
    input  logic                  cmd_issue,
    input  logic [ADDR_W-1:0]     cmd_codec,
    input  logic                  evt_full,
    output logic                  evt_push,
    output logic [WORD_W-1:0]     evt_resp,
    output logic [WORD_W-1:0]     evt_ext,
    input  logic [ADDR_W-1:0]     rd_codec,
    output logic [WORD_W-1:0]     rd_last,
    output logic [NUM_CODECS-1:0] codec_done,
    output logic                  spur_flag,
    output logic                  fatal_flag
);
    localparam int ENT_W = 2 * WORD_W;

    typedef struct packed {
        logic [PTR_W-1:0] rp;
        logic [PTR_W-1:0] tgt;
        logic             spur;
        logic             fatal;
    } walk_t;

    walk_t s_d, s_q;

    logic [PTR_W-1:0]  nxt_idx;
    logic [ENT_W-1:0]  ent;
    logic [WORD_W-1:0] e_resp, e_ext;
    logic [ADDR_W-1:0] e_addr;
    logic [15:0]       zero_w;
    logic [NUM_CODECS-1:0] codec_zero;
    entry_kind_e       kind;
    logic              have_work, advance, dec_en;

    assign nxt_idx = s_q.rp + 1'b1;

    rrd_ring_ram #(.DEPTH(RING_DEPTH), .WIDTH(ENT_W)) u_ram (
        .clk     (clk),
        .wr_en   (ring_wr_en),
        .wr_idx  (ring_wr_idx),
        .wr_data ({ring_wr_ext, ring_wr_resp}),
        .rd_idx  (nxt_idx),
        .rd_data (ent)
    );

    assign e_resp = ent[WORD_W-1:0];
    assign e_ext  = ent[ENT_W-1:WORD_W];
    assign e_addr = e_ext[ADDR_W-1:0];
    assign zero_w = 16'(codec_zero);

    always_comb begin
        s_d       = s_q;
        s_d.spur  = 1'b0;
        have_work = (s_q.rp != s_q.tgt);
        kind      = K_IDLE;
        if (have_work) begin
            if ({28'd0, e_addr} >= 32'(NUM_CODECS)) kind = K_FATAL;
            else if (e_ext[UNSOL_BIT])              kind = K_EVENT;
            else if (!zero_w[e_addr])               kind = K_REPLY;
            else                                    kind = K_SPUR;
        end
        advance  = have_work && !(kind == K_EVENT && evt_full);
        dec_en   = advance && (kind == K_REPLY);
        evt_push = advance && (kind == K_EVENT);
        if (advance) s_d.rp = nxt_idx;
        if (advance && kind == K_SPUR)  s_d.spur  = 1'b1;
        if (advance && kind == K_FATAL) s_d.fatal = 1'b1;
        if (prod_wp != WP_DEAD) s_d.tgt = prod_wp[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rrd_codec_bank #(.NUM_CODECS(NUM_CODECS), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (cmd_issue),
        .inc_addr (cmd_codec),
        .dec_en   (dec_en),
        .dec_addr (e_addr),
        .dec_data (e_resp),
        .rd_addr  (rd_codec),
        .rd_data  (rd_last),
        .zero     (codec_zero)
    );

    assign codec_done = codec_zero;
    assign evt_resp   = e_resp;
    assign evt_ext    = e_ext;
    assign spur_flag  = s_q.spur;
    assign fatal_flag = s_q.fatal;

    // R2
    rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rp != s_q.tgt && !evt_full) |=> (s_q.rp == PTR_W'($past(s_q.rp) + 1'b1)));

    // R9
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rp != s_q.tgt && kind == K_EVENT && evt_full) |=> $stable(s_q.rp));

    // R10
    dead_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_wp == WP_DEAD) |=> $stable(s_q.tgt));

    // R7
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_flag |=> fatal_flag);

    // R8
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_push |-> !evt_full);
endmodule

// File: tb/response_ring_dispatcher_bench.sv
`timescale 1ns/1ps
module response_ring_dispatcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring_wr_en = 1'b0;
    logic [7:0]  ring_wr_idx = '0;
    logic [31:0] ring_wr_resp = '0, ring_wr_ext = '0;
    logic [15:0] prod_wp = '0;
    logic        cmd_issue = 1'b0;
    logic [3:0]  cmd_codec = '0;
    logic        evt_full = 1'b0;
    logic        evt_push;
    logic [31:0] evt_resp, evt_ext;
    logic [3:0]  rd_codec = '0;
    logic [31:0] rd_last;
    logic [3:0]  codec_done;
    logic        spur_flag, fatal_flag;

    int checks = 0, errors = 0;
    int spur_cnt = 0, evt_cnt = 0;
    logic [31:0] evt_log_r [16];
    logic [31:0] evt_log_x [16];

    always #5 clk = ~clk;

    response_ring_dispatcher u_response_ring_dispatcher (
        .clk(clk), .rst_n(rst_n), .ring_wr_en(ring_wr_en), .ring_wr_idx(ring_wr_idx),
        .ring_wr_resp(ring_wr_resp), .ring_wr_ext(ring_wr_ext), .prod_wp(prod_wp),
        .cmd_issue(cmd_issue), .cmd_codec(cmd_codec), .evt_full(evt_full),
        .evt_push(evt_push), .evt_resp(evt_resp), .evt_ext(evt_ext),
        .rd_codec(rd_codec), .rd_last(rd_last), .codec_done(codec_done),
        .spur_flag(spur_flag), .fatal_flag(fatal_flag)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (spur_flag) spur_cnt++;
            if (evt_push) begin
                if (evt_cnt < 16) begin
                    evt_log_r[evt_cnt] = evt_resp;
                    evt_log_x[evt_cnt] = evt_ext;
                end
                evt_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ext word: bits[3:0] codec, bit 4 unsolicited (R4)
    task automatic put(input int idx, input logic [31:0] resp, input logic [3:0] codec, input logic unsol);
        @(negedge clk);
        ring_wr_en   = 1'b1;
        ring_wr_idx  = 8'(idx);
        ring_wr_resp = resp;
        ring_wr_ext  = {27'd0, unsol, codec};
        @(negedge clk);
        ring_wr_en   = 1'b0;
    endtask

    task automatic issue(input logic [3:0] codec, input int n);
        @(negedge clk);
        cmd_codec = codec;
        cmd_issue = 1'b1;
        tick(n);
        cmd_issue = 1'b0;
    endtask

    task automatic last_of(input logic [3:0] codec, output logic [31:0] v);
        rd_codec = codec;
        #1;
        v = rd_last;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 done", 64'(codec_done), 64'hF);
        check("R1 spur", 64'(spur_flag), 64'h0);
        check("R1 fatal", 64'(fatal_flag), 64'h0);
        check("R1 push", 64'(evt_push), 64'h0);
        last_of(4'd3, v);
        check("R1 last", 64'(v), 64'h0);
    endtask

    task automatic t_solicited();
        logic [31:0] v;
        int s0 = spur_cnt;
        issue(4'd1, 2);
        check("R11 pending raised", 64'(codec_done[1]), 64'h0);
        put(0, 32'hDEAD0000, 4'd1, 1'b0);
        put(1, 32'h11111111, 4'd1, 1'b0);
        put(2, 32'h22222222, 4'd1, 1'b0);
        prod_wp = 16'd2;
        tick(6);
        check("R5 done after replies", 64'(codec_done[1]), 64'h1);
        last_of(4'd1, v);
        check("R12 R5 last value", 64'(v), 64'h22222222);
        check("R2 entry 0 skipped", 64'(spur_cnt - s0), 64'h0);
    endtask

    task automatic t_spurious();
        logic [31:0] v;
        int s0 = spur_cnt;
        put(3, 32'h33333333, 4'd2, 1'b0);
        prod_wp = 16'd3;
        tick(5);
        check("R6 spur pulse", 64'(spur_cnt - s0), 64'h1);
        last_of(4'd2, v);
        check("R6 last unchanged", 64'(v), 64'h0);
    endtask

    task automatic t_fatal();
        logic [31:0] v;
        issue(4'd1, 1);
        put(4, 32'h44444444, 4'd9, 1'b0);
        put(5, 32'h55555555, 4'd1, 1'b0);
        prod_wp = 16'd5;
        tick(6);
        check("R7 fatal set", 64'(fatal_flag), 64'h1);
        check("R7 entry consumed, next served", 64'(codec_done), 64'hF);
        last_of(4'd1, v);
        check("R7 no store from bad entry", 64'(v), 64'h55555555);
    endtask

    task automatic t_event();
        logic [31:0] v;
        int e0 = evt_cnt;
        issue(4'd3, 1);
        put(6, 32'hE0E0E0E0, 4'd0, 1'b1);
        put(7, 32'hE3E3E3E3, 4'd3, 1'b1);
        put(8, 32'h88888888, 4'd3, 1'b0);
        prod_wp = 16'd8;
        tick(6);
        check("R8 two events", 64'(evt_cnt - e0), 64'h2);
        check("R8 first event", {evt_log_x[e0], evt_log_r[e0]}, {32'h10, 32'hE0E0E0E0});
        check("R8 second event", {evt_log_x[e0+1], evt_log_r[e0+1]}, {32'h13, 32'hE3E3E3E3});
        last_of(4'd3, v);
        check("R8 reply after events", 64'(v), 64'h88888888);
        check("R8 counts intact", 64'(codec_done), 64'hF);
    endtask

    task automatic t_stall();
        int e0 = evt_cnt;
        issue(4'd0, 1);
        put(9, 32'h99999999, 4'd2, 1'b1);
        put(10, 32'hAAAAAAAA, 4'd0, 1'b0);
        evt_full = 1'b1;
        prod_wp = 16'd10;
        tick(8);
        check("R9 no push while full", 64'(evt_cnt - e0), 64'h0);
        check("R9 later reply waits", 64'(codec_done[0]), 64'h0);
        evt_full = 1'b0;
        tick(5);
        check("R9 push after release", 64'(evt_cnt - e0), 64'h1);
        check("R9 reply after release", 64'(codec_done[0]), 64'h1);
    endtask

    task automatic t_deadwp();
        issue(4'd1, 1);
        put(11, 32'hBBBBBBBB, 4'd1, 1'b0);
        prod_wp = 16'hFFFF;
        tick(6);
        check("R10 dead pointer ignored", 64'(codec_done[1]), 64'h0);
        prod_wp = 16'd11;
        tick(5);
        check("R10 resumes on real pointer", 64'(codec_done[1]), 64'h1);
    endtask

    task automatic t_cancel();
        int s0 = spur_cnt;
        issue(4'd0, 2);
        put(12, 32'hC0C0C0C0, 4'd0, 1'b0);
        put(13, 32'hC1C1C1C1, 4'd0, 1'b0);
        prod_wp = 16'd13;
        @(negedge clk);
        cmd_codec = 4'd0;
        cmd_issue = 1'b1;
        tick(2);
        cmd_issue = 1'b0;
        tick(3);
        check("R11 same-cycle cancel keeps count", 64'(codec_done[0]), 64'h0);
        put(14, 32'hC2C2C2C2, 4'd0, 1'b0);
        put(15, 32'hC3C3C3C3, 4'd0, 1'b0);
        prod_wp = 16'd15;
        tick(5);
        check("R11 two left exactly", 64'(codec_done[0]), 64'h1);
        check("R11 no spurious", 64'(spur_cnt - s0), 64'h0);
        issue(4'd7, 1);
        tick(2);
        check("R11 bad address strobe ignored", 64'(codec_done), 64'hF);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int s0 = spur_cnt;
        for (int i = 16; i < 256; i++) put(i, 32'(i), 4'd2, 1'b0);
        issue(4'd2, 240);
        prod_wp = 16'd255;
        tick(250);
        last_of(4'd2, v);
        check("R3 reached index 255", 64'(v), 64'hFF);
        for (int i = 0; i < 6; i++) put(i, 32'h100 + 32'(i), 4'd2, 1'b0);
        issue(4'd2, 6);
        prod_wp = 16'd5;
        tick(10);
        last_of(4'd2, v);
        check("R3 wrapped through 0", 64'(v), 64'h105);
        check("R3 all replies matched", 64'(codec_done[2]), 64'h1);
        check("R3 no spurious on wrap", 64'(spur_cnt - s0), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_solicited();
        t_spurious();
        t_fatal();
        t_event();
        t_stall();
        t_deadwp();
        t_cancel();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule